// File: doc/BRIEF.md
# Host Data Buffer with DMA Handshake

This block is the byte path between a host microprocessor port and a SCSI-side byte stream. It holds a two-stage byte buffer, a flag that shows whether the buffer holds data, and a 24-bit transfer counter. The host reaches the counter and the data register by chip select plus address. The data register can also be reached through a DMA request/acknowledge handshake. The SCSI side is a plain valid/ready byte stream. It moves bytes out of the buffer in the send direction and into the buffer in the receive direction.

A transfer starts when the host loads an interrupting-type command. That load empties the buffer and latches three settings: DMA mode (bit 7 of the command byte, on `cmd_dma`), single-byte mode (bit 6, on `cmd_single`) and direction (`cmd_send`). In multi-byte mode the counter sets the length. It counts down once per byte that crosses the SCSI side, and the transfer ends when it reaches zero. In single-byte mode exactly one byte crosses, and the counter keeps its value.

Top module: `hostbuf_dma`

## Requirements
- R1: After synchronous reset, `buf_full`=0, `cnt_zero`=1, `dreq`=0, `xfer_active`=0, `out_valid`=0, `in_ready`=0 and `hrdata`=0.
- R2: The buffer holds at most two bytes and delivers them oldest first. A byte offered while both stages are occupied is dropped, even if a byte leaves in the same cycle.
- R3: `buf_full` is 1 while at least one stage holds a byte. It is 0 only when both stages are empty.
- R4: A command load with `cmd_intr`=1 does four things. It empties the buffer. It latches `cmd_dma`, `cmd_single` and `cmd_send`. It sets `xfer_active` to 1 if `cmd_single`=1 or the counter is nonzero. It drops any data strobe or SCSI byte in the same cycle. A load with `cmd_intr`=0 changes nothing.
- R5: With DMA mode 0, the data register is accessed by `hcs`=1, `haddr`=4'b0000 and `hwr` or `hrd`. `dack` has no effect on the data.
- R6: With DMA mode 1, the data register is accessed only by `dack`=1 with `hwr` or `hrd`. A chip-select access to address 4'b0000 moves no data, and such a read returns 0.
- R7: `dreq` is registered. It is 1 in the cycle after one where all of the following hold: DMA mode is 1; in send, the transfer may move a byte and a stage is free, or in receive, a byte is held; there is no `dack` strobe; and there is no interrupting command load.
- R8: The counter bytes are at `haddr` 4'b1100 (bits 23:16), 4'b1101 (bits 15:8) and 4'b1110 (bits 7:0). A chip-select write replaces that byte, and a read returns it. A counter write beats a decrement in the same cycle.
- R9: In multi-byte mode the counter decrements by one for each byte that crosses the SCSI side. `xfer_active` falls after the byte that brings the counter to zero, and no byte moves while the counter is zero.
- R10: In single-byte mode exactly one byte crosses the SCSI side, then `xfer_active` falls. The counter is unchanged.
- R11: `cnt_zero` is 1 exactly when the counter value is zero.
- R12: In send, `out_valid` is 1 when the transfer may move a byte and the buffer holds one. `out_data` is the oldest byte, and it leaves on `out_ready`. In receive, `in_ready` is 1 when the transfer may move a byte and a stage is free, and `in_data` is stored on `in_valid`.
- R13: `hrdata` is registered. After a data-register read it shows the byte removed, or 0 if none was removed. After a counter read it shows the counter byte. After a read of any other address it shows 0. It holds its value when there is no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hcs | input | 1 | Host chip select |
| haddr | input | 4 | Host register address |
| hrd | input | 1 | Host read strobe (one cycle) |
| hwr | input | 1 | Host write strobe (one cycle) |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Registered host read data |
| dack | input | 1 | DMA acknowledge, qualifies hrd/hwr |
| dreq | output | 1 | DMA request |
| cmd_load | input | 1 | Command register write pulse |
| cmd_intr | input | 1 | Loaded command is interrupting type |
| cmd_dma | input | 1 | Command bit 7, DMA mode |
| cmd_single | input | 1 | Command bit 6, single-byte mode |
| cmd_send | input | 1 | 1 = host to SCSI, 0 = SCSI to host |
| buf_full | output | 1 | Data register holds data |
| cnt_zero | output | 1 | Transfer counter equals zero |
| xfer_active | output | 1 | A transfer may move bytes |
| out_valid | output | 1 | SCSI-side send byte valid |
| out_ready | input | 1 | SCSI side takes the send byte |
| out_data | output | 8 | SCSI-side send byte |
| in_valid | input | 1 | SCSI-side receive byte valid |
| in_ready | output | 1 | Buffer can take a receive byte |
| in_data | input | 8 | SCSI-side receive byte |

## Verification
Two things can fall in the same cycle and must both be judged: a host or DMA strobe on the data register, and a byte crossing the SCSI side, both acting on the same two stages. A counter write can also coincide with a decrement. Independent random host, DMA and stream activity provokes these collisions often, alongside directed cases with one byte already held. A bench model built from the requirements judges every cycle's buffer occupancy, oldest byte, counter-zero state, `dreq` and read data.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int HADDR_W = 4;
  localparam logic [HADDR_W-1:0] DATA_ADDR     = 4'h0;
  localparam logic [HADDR_W-1:0] CNT_ADDR_BASE = 4'hC;

  typedef struct packed {
    logic dma;
    logic single;
    logic send;
  } xfer_mode_t;
endpackage

// File: rtl/dbuf_fifo.sv
module dbuf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wptr <= step_ptr(wptr);
      if (pop)  rptr <= step_ptr(rptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata = mem[rptr];
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |-> (cnt_q < CW'(DEPTH)));  // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop && !clr) |-> (cnt_q != '0));  // R2
endmodule

// File: rtl/dbuf_tcount.sv
module dbuf_tcount #(
  parameter int W  = 24,
  parameter int BW = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(W/BW)-1:0]     wr_idx,
  input  logic [BW-1:0]               wr_byte,
  input  logic                        dec,
  output logic [W-1:0]                cnt
);
  localparam int NB = W / BW;
  localparam int IW = $clog2(NB);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_idx == IW'(b)) cnt_d[b*BW +: BW] = wr_byte;
      end
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0));  // R9
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (dec && !wr_en) |=> (cnt_q == $past(cnt_q) - W'(1)));  // R9
endmodule

// File: rtl/dbuf_dreq.sv
module dbuf_dreq (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic strobe,
  input  logic clr,
  output logic dreq
);
  logic dreq_q;

  always_ff @(posedge clk) begin
    if (rst) dreq_q <= 1'b0;
    else     dreq_q <= want && !strobe && !clr;
  end

  assign dreq = dreq_q;
endmodule

// File: rtl/hostbuf_dma.sv
module hostbuf_dma
  import dbuf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 24,
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hcs,
  input  logic [HADDR_W-1:0] haddr,
  input  logic               hrd,
  input  logic               hwr,
  input  logic [DW-1:0]      hwdata,
  output logic [DW-1:0]      hrdata,
  input  logic               dack,
  output logic               dreq,
  input  logic               cmd_load,
  input  logic               cmd_intr,
  input  logic               cmd_dma,
  input  logic               cmd_single,
  input  logic               cmd_send,
  output logic               buf_full,
  output logic               cnt_zero,
  output logic               xfer_active,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DW-1:0]      out_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      in_data
);
  localparam int NB = CNT_W / DW;
  localparam int IW = $clog2(NB);
  localparam int CW = $clog2(DEPTH + 1);

  xfer_mode_t      mode_q;
  logic            active_q;
  logic [DW-1:0]   hrdata_q;
  logic [CW-1:0]   count;
  logic [DW-1:0]   head;
  logic [CNT_W-1:0] cnt;

  logic cmd_clr, data_sel, has_byte, has_room, xfer_ok;
  logic fire_tx, fire_rx, fire, push_h, pop_h;
  logic fifo_push, fifo_pop;
  logic cnt_hit, cnt_wr, cnt_dec;
  logic [HADDR_W-1:0] cnt_off;
  logic [IW-1:0]      cnt_idx;
  logic [DW-1:0]      cnt_byte;
  logic dreq_want, dma_strobe;

  // host-side decode
  assign cmd_clr  = cmd_load && cmd_intr;
  assign data_sel = mode_q.dma ? dack : (hcs && (haddr == DATA_ADDR));
  assign has_byte = (count != '0);
  assign has_room = (count < CW'(DEPTH));
  assign xfer_ok  = active_q && (mode_q.single || (cnt != '0));

  // byte movement on both sides
  assign fire_tx = xfer_ok &&  mode_q.send && has_byte && out_ready && !cmd_clr;
  assign fire_rx = xfer_ok && !mode_q.send && has_room && in_valid  && !cmd_clr;
  assign fire    = fire_tx || fire_rx;
  assign push_h  = data_sel && hwr &&  mode_q.send && has_room && !cmd_clr;
  assign pop_h   = data_sel && hrd && !mode_q.send && has_byte && !cmd_clr;

  assign fifo_push = push_h || fire_rx;
  assign fifo_pop  = pop_h  || fire_tx;

  dbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .clr   (cmd_clr),
    .push  (fifo_push),
    .pop   (fifo_pop),
    .wdata (mode_q.send ? hwdata : in_data),
    .rdata (head),
    .count (count)
  );

  // counter byte decode: base address holds the top byte
  always_comb begin
    cnt_off  = haddr - CNT_ADDR_BASE;
    cnt_hit  = hcs && (haddr >= CNT_ADDR_BASE) && (cnt_off < HADDR_W'(NB));
    cnt_idx  = IW'(NB - 1) - cnt_off[IW-1:0];
    cnt_byte = '0;
    for (int b = 0; b < NB; b++) begin
      if (cnt_idx == IW'(b)) cnt_byte = cnt[b*DW +: DW];
    end
  end

  assign cnt_wr  = cnt_hit && hwr;
  assign cnt_dec = fire && !mode_q.single;

  dbuf_tcount #(.W(CNT_W), .BW(DW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cnt_wr),
    .wr_idx  (cnt_idx),
    .wr_byte (hwdata),
    .dec     (cnt_dec),
    .cnt     (cnt)
  );

  // transfer state
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      active_q <= 1'b0;
    end else if (cmd_clr) begin
      mode_q   <= '{dma: cmd_dma, single: cmd_single, send: cmd_send};
      active_q <= cmd_single || (cnt != '0);
    end else if (fire && (mode_q.single || (cnt == CNT_W'(1)))) begin
      active_q <= 1'b0;
    end else if (active_q && !mode_q.single && (cnt == '0)) begin
      active_q <= 1'b0;
    end
  end

  // DMA request
  assign dreq_want  = mode_q.dma && (mode_q.send ? (xfer_ok && has_room) : has_byte);
  assign dma_strobe = mode_q.dma && dack && (hrd || hwr);

  dbuf_dreq u_dreq (
    .clk    (clk),
    .rst    (rst),
    .want   (dreq_want),
    .strobe (dma_strobe),
    .clr    (cmd_clr),
    .dreq   (dreq)
  );

  // registered host read data
  always_ff @(posedge clk) begin
    if (rst) begin
      hrdata_q <= '0;
    end else if (hrd && (data_sel || hcs)) begin
      if (data_sel)     hrdata_q <= pop_h ? head : '0;
      else if (cnt_hit) hrdata_q <= cnt_byte;
      else              hrdata_q <= '0;
    end
  end

  assign hrdata      = hrdata_q;
  assign buf_full    = has_byte;
  assign cnt_zero    = (cnt == '0);
  assign xfer_active = active_q;
  assign out_valid   = xfer_ok && mode_q.send && has_byte;
  assign out_data    = head;
  assign in_ready    = xfer_ok && !mode_q.send && has_room;

  AST_DREQ_DROP: assert property (@(posedge clk) disable iff (rst)
    dma_strobe |=> !dreq);  // R7
  AST_CMD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    cmd_clr |=> !buf_full);  // R4
  AST_SINGLE_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
    (fire && mode_q.single && !cnt_wr && !cmd_clr) |=> $stable(cnt));  // R10
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (active_q && !mode_q.single && (cnt == '0) && !cmd_clr) |=> !xfer_active);  // R9
  AST_OUT_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> buf_full);  // R12
endmodule

// File: tb/sim_hostbuf_dma.sv
module sim_hostbuf_dma;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hcs, hrd, hwr, dack, cmd_load, cmd_intr, cmd_dma, cmd_single, cmd_send;
  logic out_ready, in_valid;
  logic [3:0] haddr;
  logic [7:0] hwdata, in_data;
  logic [7:0] hrdata, out_data;
  logic dreq, buf_full, cnt_zero, xfer_active, out_valid, in_ready;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  hostbuf_dma u0 (
    .clk(clk), .rst(rst), .hcs(hcs), .haddr(haddr), .hrd(hrd), .hwr(hwr),
    .hwdata(hwdata), .hrdata(hrdata), .dack(dack), .dreq(dreq),
    .cmd_load(cmd_load), .cmd_intr(cmd_intr), .cmd_dma(cmd_dma),
    .cmd_single(cmd_single), .cmd_send(cmd_send), .buf_full(buf_full),
    .cnt_zero(cnt_zero), .xfer_active(xfer_active), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data)
  );

  // reference model state
  logic [7:0]  q[$];
  logic [23:0] mcnt;
  logic        mact, mdma, msingle, msend, mdreq;
  logic [7:0]  mrd;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    hcs = 0; haddr = 0; hrd = 0; hwr = 0; hwdata = 0; dack = 0;
    cmd_load = 0; cmd_intr = 0; cmd_dma = 0; cmd_single = 0; cmd_send = 0;
    in_valid = 0; in_data = 0;
  endtask

  task automatic model_step();
    logic cclr, dsel, hb, hr, ok, ftx, frx, ph, pp, hit, cwr, fire, want, strb;
    logic [7:0] head, nb;
    cclr = cmd_load && cmd_intr;
    dsel = mdma ? dack : (hcs && haddr == 4'h0);
    hb   = q.size() > 0;
    hr   = q.size() < 2;
    ok   = mact && (msingle || mcnt != 0);
    ftx  = ok && msend && hb && out_ready && !cclr;
    frx  = ok && !msend && hr && in_valid && !cclr;
    ph   = dsel && hwr && msend && hr && !cclr;
    pp   = dsel && hrd && !msend && hb && !cclr;
    hit  = hcs && haddr >= 4'hC && haddr <= 4'hE;
    cwr  = hit && hwr;
    fire = ftx || frx;
    head = hb ? q[0] : 8'h00;
    want = mdma && (msend ? (ok && hr) : hb);
    strb = mdma && dack && (hrd || hwr);
    if (hrd && (dsel || hcs)) begin
      if (dsel)     mrd = pp ? head : 8'h00;
      else if (hit) mrd = 8'((mcnt >> (8 * (14 - int'(haddr)))) & 24'hFF);
      else          mrd = 8'h00;
    end
    mdreq = want && !strb && !cclr;
    if (cclr) begin
      mact = cmd_single || (mcnt != 0);
    end else if (fire && (msingle || mcnt == 1)) begin
      mact = 0;
    end else if (mact && !msingle && mcnt == 0) begin
      mact = 0;
    end
    if (cwr) begin
      nb = hwdata;
      case (haddr)
        4'hC: mcnt[23:16] = nb;
        4'hD: mcnt[15:8]  = nb;
        default: mcnt[7:0] = nb;
      endcase
    end else if (fire && !msingle && mcnt != 0) begin
      mcnt = mcnt - 1;
    end
    if (cclr) begin
      q.delete();
      mdma = cmd_dma; msingle = cmd_single; msend = cmd_send;
    end else begin
      if (pp || ftx) void'(q.pop_front());
      if (ph || frx) q.push_back(msend ? hwdata : in_data);
    end
  endtask

  task automatic check_all();
    logic ok;
    ok = mact && (msingle || mcnt != 0);
    chk("R3",  "buf_full",    buf_full,    q.size() != 0);
    chk("R11", "cnt_zero",    cnt_zero,    mcnt == 0);
    chk("R7",  "dreq",        dreq,        mdreq);
    chk("R9",  "xfer_active", xfer_active, mact);
    chk("R12", "out_valid",   out_valid,   ok && msend && q.size() != 0);
    chk("R12", "in_ready",    in_ready,    ok && !msend && q.size() < 2);
    chk("R13", "hrdata",      hrdata,      mrd);
    if (msend && q.size() != 0) chk("R2", "out_data", out_data, q[0]);
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic hwrite(logic [3:0] a, logic [7:0] d);
    idle(); hcs = 1; haddr = a; hwr = 1; hwdata = d; step(); idle();
  endtask

  task automatic hread(logic [3:0] a);
    idle(); hcs = 1; haddr = a; hrd = 1; step(); idle();
  endtask

  task automatic cmd(logic intr, logic dma, logic single, logic send);
    idle(); cmd_load = 1; cmd_intr = intr; cmd_dma = dma;
    cmd_single = single; cmd_send = send; step(); idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    idle(); out_ready = 0;
    q.delete(); mcnt = 0; mact = 0; mdma = 0; msingle = 0; msend = 0;
    mdreq = 0; mrd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", "buf_full",    buf_full,    0);
    chk("R1", "cnt_zero",    cnt_zero,    1);
    chk("R1", "dreq",        dreq,        0);
    chk("R1", "xfer_active", xfer_active, 0);
    chk("R1", "out_valid",   out_valid,   0);
    chk("R1", "in_ready",    in_ready,    0);
    chk("R1", "hrdata",      hrdata,      0);

    // R8 counter byte addressing
    hwrite(4'hC, 8'h00); hwrite(4'hD, 8'h5A); hwrite(4'hE, 8'h03);
    hread(4'hD); chk("R8", "mid byte", hrdata, 8'h5A);
    hread(4'hE); chk("R8", "low byte", hrdata, 8'h03);
    hwrite(4'hD, 8'h00);

    // send, host polling, multi-byte of 3
    cmd(1, 0, 0, 1);
    hwrite(4'h0, 8'hA1); hwrite(4'h0, 8'hA2);
    chk("R3", "two held", buf_full, 1);
    hwrite(4'h0, 8'hA3);
    cmd(0, 1, 1, 0);
    chk("R4", "non-interrupting load keeps data", buf_full, 1);
    chk("R2", "oldest first", out_data, 8'hA1);
    out_ready = 1; step();
    chk("R2", "third byte was dropped", out_data, 8'hA2);
    step();
    chk("R3", "empty after drain", buf_full, 0);
    idle(); dack = 1; hwr = 1; hwdata = 8'h55; step(); idle();
    chk("R5", "dack ignored without DMA mode", buf_full, 0);
    hwrite(4'h0, 8'h66); step();
    chk("R9", "stops at zero", xfer_active, 0);
    chk("R11", "count reached zero", cnt_zero, 1);
    out_ready = 0;

    // single-byte receive keeps counter
    hwrite(4'hE, 8'h05);
    cmd(1, 0, 1, 0);
    idle(); in_valid = 1; in_data = 8'h77; step(); idle();
    chk("R10", "single ends", xfer_active, 0);
    hread(4'hE); chk("R10", "counter unchanged", hrdata, 8'h05);
    hread(4'h0); chk("R5", "polled read", hrdata, 8'h77);

    // DMA receive
    cmd(1, 1, 0, 0);
    idle(); in_valid = 1; in_data = 8'h88; step(); idle();
    step();
    chk("R7", "dreq with byte held", dreq, 1);
    hread(4'h0);
    chk("R6", "chip select read in DMA mode", hrdata, 8'h00);
    chk("R6", "data kept", buf_full, 1);
    idle(); dack = 1; hrd = 1; step(); idle();
    chk("R6", "DMA read data", hrdata, 8'h88);
    chk("R7", "dreq dropped after strobe", dreq, 0);

    // command load collides with a data write
    cmd(1, 0, 0, 1);
    hwrite(4'h0, 8'h11);
    idle(); cmd_load = 1; cmd_intr = 1; cmd_send = 1;
    hcs = 1; haddr = 4'h0; hwr = 1; hwdata = 8'h22; step(); idle();
    chk("R4", "load drops same-cycle write", buf_full, 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int unsigned r;
      idle();
      hcs = ($urandom % 3) == 0;
      r = $urandom % 5;
      haddr = (r == 0) ? 4'h0 : (r == 1) ? 4'hC : (r == 2) ? 4'hD :
              (r == 3) ? 4'hE : 4'($urandom % 16);
      hrd = ($urandom % 2) == 0;
      hwr = ($urandom % 2) == 0;
      hwdata = 8'($urandom);
      if (hwr && haddr inside {4'hC, 4'hD}) hwdata = 8'h00;
      if (hwr && haddr == 4'hE) hwdata = 8'($urandom % 6);
      dack = ($urandom % 3) == 0;
      cmd_load = ($urandom % 30) == 0;
      cmd_intr = ($urandom % 4) != 0;
      cmd_dma = ($urandom % 2) == 0;
      cmd_single = ($urandom % 3) == 0;
      cmd_send = ($urandom % 2) == 0;
      out_ready = ($urandom % 2) == 0;
      in_valid = ($urandom % 2) == 0;
      in_data = 8'($urandom);
      step();
    end
    idle();
    summary();
  end
endmodule